// File: doc/BRIEF.md
# Bit Manipulation and Test Unit

This unit carries out single-bit operations on one byte in the low 256-byte page of memory. A sequencer hands it an opcode and the operand's direct address. For a set or clear, the unit reads the byte, forces the selected bit and writes the byte back. For a test, the unit reads the byte and reports whether a branch should be taken. The tested bit is also copied into a carry flag that the unit holds.

All memory traffic goes through a request/acknowledge handshake. A request, with its address, write enable and write data, is held until the memory acknowledges it. Read data is taken in the cycle of the acknowledge. Each operation ends with a one-cycle done pulse. A new operation may be started in that same done cycle, so back-to-back operations need no idle gap.

The unit does not form branch targets or operand addresses. It writes back whatever the read returned, whatever the address. Registers that cannot be read, such as direction registers, therefore get corrupted unaffected bits. This matches the behaviour the surrounding system expects.

Top module: `bit_manip_unit`

## Requirements
- R1: While reset is held and after it, busy, mem_req, mem_we, done, taken and carry are all 0.
- R2: Opcode decode. Bits [3:1] give the bit number n. Bit 4 selects the kind: 0 is test, 1 is modify. For a test, bit 0 equal to 0 means branch if set and 1 means branch if clear. For a modify, bit 0 equal to 0 means set and 1 means clear. Bits [7:5] must be zero.
- R3: The cycle after a legal start is accepted, mem_req is 1, mem_we is 0 and mem_addr equals the operand address. All three are held until mem_ack is seen.
- R4: For set or clear, after the read a write request is raised on the same address. Its mem_wdata is the read byte with bit n forced to 1 (set) or 0 (clear), and the other seven bits are unchanged. It is held until mem_ack.
- R5: The write-back does not depend on the address. A location that reads as 8'hFF (a write-only register) is written as 8'hFF for a set, or as 8'hFF with bit n cleared for a clear.
- R6: A test never raises mem_we. In its done cycle, taken is 1 exactly when bit n of the read byte equals 1 for branch-if-set, or equals 0 for branch-if-clear. Outside done, taken is 0.
- R7: After a test, carry equals bit n of the read byte, whether or not the branch is taken. A set, a clear or an illegal opcode leaves carry unchanged. Carry changes only in a done cycle.
- R8: done is a single-cycle pulse. With zero acknowledge wait, it arrives 3 cycles after acceptance for a test and 4 cycles after acceptance for a set or clear. Each wait cycle on a handshake adds one cycle.
- R9: busy is 1 from acceptance until done. A start while the unit is reading, modifying or writing is ignored.
- R10: A start in the done cycle is accepted, and the read request appears in the next cycle.
- R11: An opcode with a nonzero bit in [7:5] makes no memory request. It gives done in the next cycle with taken at 0 and carry unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Begin an operation (taken when idle or done) |
| opcode | input | 8 | Operation code, see R2 |
| opaddr | input | ADDR_W | Direct operand address |
| busy | output | 1 | Operation in progress |
| mem_req | output | 1 | Memory request, held until mem_ack |
| mem_we | output | 1 | Request is a write |
| mem_addr | output | ADDR_W | Request address |
| mem_wdata | output | 8 | Write-back byte |
| mem_rdata | input | 8 | Read data, valid with mem_ack |
| mem_ack | input | 1 | Memory acknowledge |
| done | output | 1 | One-cycle completion pulse |
| taken | output | 1 | Branch decision, valid with done |
| carry | output | 1 | Carry flag holding the last tested bit |

## Verification
Two events can fall in the same cycle: the done pulse of one operation and the acceptance of the next. The bench provokes this by issuing operations with a zero gap, including an illegal opcode issued from a done cycle. It also raises stray starts with a junk opcode while the unit is busy. A behavioural reference model runs beside the design. It decides from the requirements alone whether each start is accepted or dropped. Every clock, the design's request, data, done, taken and carry values are compared with the model's.

// File: rtl/bit_manip_unit.sv
module bit_manip_unit #(
  parameter int ADDR_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic [7:0]        opcode,
  input  logic [ADDR_W-1:0] opaddr,
  output logic              busy,
  output logic              mem_req,
  output logic              mem_we,
  output logic [ADDR_W-1:0] mem_addr,
  output logic [7:0]        mem_wdata,
  input  logic [7:0]        mem_rdata,
  input  logic              mem_ack,
  output logic              done,
  output logic              taken,
  output logic              carry
);

  typedef enum logic [2:0] {S_IDLE, S_READ, S_MOD, S_WRITE, S_DONE} st_t;

  st_t               st_q;
  logic [4:0]        op_q;
  logic [ADDR_W-1:0] addr_q;
  logic [7:0]        rd_q, wb_q;
  logic              tk_q, cy_q;

  logic       legal, accept, tested;
  logic [2:0] bitsel;
  logic [7:0] mask;

  assign legal  = (opcode[7:5] == 3'b000);
  assign accept = start && (st_q == S_IDLE || st_q == S_DONE);
  assign bitsel = op_q[3:1];
  assign mask   = 8'b1 << bitsel;
  assign tested = rd_q[bitsel];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st_q   <= S_IDLE;
      op_q   <= '0;
      addr_q <= '0;
      rd_q   <= '0;
      wb_q   <= '0;
      tk_q   <= 1'b0;
      cy_q   <= 1'b0;
    end else begin
      case (st_q)
        S_IDLE, S_DONE: begin
          if (accept) begin
            op_q   <= opcode[4:0];
            addr_q <= opaddr;
            tk_q   <= 1'b0;
            st_q   <= legal ? S_READ : S_DONE;
          end else begin
            st_q <= S_IDLE;
          end
        end
        S_READ: begin
          if (mem_ack) begin
            rd_q <= mem_rdata;
            st_q <= S_MOD;
          end
        end
        S_MOD: begin
          if (op_q[4]) begin
            wb_q <= op_q[0] ? (rd_q & ~mask) : (rd_q | mask);
            st_q <= S_WRITE;
          end else begin
            tk_q <= tested ^ op_q[0];
            cy_q <= tested;
            st_q <= S_DONE;
          end
        end
        S_WRITE: begin
          if (mem_ack) st_q <= S_DONE;
        end
        default: st_q <= S_IDLE;
      endcase
    end
  end

  assign busy      = (st_q != S_IDLE);
  assign mem_req   = (st_q == S_READ) || (st_q == S_WRITE);
  assign mem_we    = (st_q == S_WRITE);
  assign mem_addr  = addr_q;
  assign mem_wdata = wb_q;
  assign done      = (st_q == S_DONE);
  assign taken     = done & tk_q;
  assign carry     = cy_q;

  // R3
  req_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req && !mem_ack) |=> (mem_req && $stable(mem_addr) && $stable(mem_we)));

  // R4
  wdata_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
    mem_we |-> (((mem_wdata ^ rd_q) & ~mask) == 8'h00));

  // R6
  test_no_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
    mem_we |-> op_q[4]);

  // R7
  carry_at_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(carry) |-> done);

  // R8
  done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (done && !start) |=> !done);

  // R11
  illegal_skip_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (start && !legal && !busy) |=> (done && !mem_req && !taken));

endmodule

// File: tb/sim_bit_manip_unit.sv
`timescale 1ns/1ps
module sim_bit_manip_unit;
  localparam int NOPS = 36;

  logic clk = 1'b0;
  logic rst_n;
  logic start, mem_ack;
  logic [7:0] opcode, opaddr, mem_rdata;
  logic busy, mem_req, mem_we, done, taken, carry;
  logic [7:0] mem_addr, mem_wdata;

  always #2.5 clk = ~clk;

  bit_manip_unit #(.ADDR_W(8)) u0 (
    .clk(clk), .rst_n(rst_n), .start(start), .opcode(opcode), .opaddr(opaddr),
    .busy(busy), .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr),
    .mem_wdata(mem_wdata), .mem_rdata(mem_rdata), .mem_ack(mem_ack),
    .done(done), .taken(taken), .carry(carry));

  int total = 0;
  int bad = 0;

  logic [7:0] mem [0:255];
  logic [7:0] q_op [0:NOPS-1];
  logic [7:0] q_ad [0:NOPS-1];
  int q_lat [0:NOPS-1];
  int q_gap [0:NOPS-1];
  bit q_noise [0:NOPS-1];

  int ph;
  logic [7:0] m_op, m_addr, m_rd, m_wb;
  logic m_tk, m_cy;
  bit m_ill, m_b2b;

  task automatic chk(input bit ok, input string tag, input logic [7:0] act, input logic [7:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h t=%0t", tag, act, exp, $time);
    end
  endtask

  function automatic bit wo(input logic [7:0] a);
    return (a >= 8'h04 && a <= 8'h06);
  endfunction

  initial begin
    for (int i = 0; i < 256; i++) mem[i] = 8'((i * 37 + 5) & 8'hFF);
    q_op[0] = 8'h10; q_ad[0] = 8'h20; q_lat[0] = 0; q_gap[0] = 1; q_noise[0] = 0;
    q_op[1] = 8'h1F; q_ad[1] = 8'h21; q_lat[1] = 2; q_gap[1] = 0; q_noise[1] = 1;
    q_op[2] = 8'h00; q_ad[2] = 8'h20; q_lat[2] = 0; q_gap[2] = 2; q_noise[2] = 0;
    q_op[3] = 8'h01; q_ad[3] = 8'h20; q_lat[3] = 1; q_gap[3] = 0; q_noise[3] = 0;
    q_op[4] = 8'h1C; q_ad[4] = 8'h30; q_lat[4] = 0; q_gap[4] = 0; q_noise[4] = 0;
    q_op[5] = 8'h0F; q_ad[5] = 8'h21; q_lat[5] = 0; q_gap[5] = 1; q_noise[5] = 0;
    q_op[6] = 8'h16; q_ad[6] = 8'h05; q_lat[6] = 1; q_gap[6] = 0; q_noise[6] = 0;
    q_op[7] = 8'h15; q_ad[7] = 8'h04; q_lat[7] = 0; q_gap[7] = 0; q_noise[7] = 1;
    q_op[8] = 8'h40; q_ad[8] = 8'h10; q_lat[8] = 0; q_gap[8] = 0; q_noise[8] = 0;
    q_op[9] = 8'hE3; q_ad[9] = 8'h11; q_lat[9] = 0; q_gap[9] = 0; q_noise[9] = 0;
    q_op[10] = 8'h0A; q_ad[10] = 8'h06; q_lat[10] = 2; q_gap[10] = 3; q_noise[10] = 0;
    q_op[11] = 8'h13; q_ad[11] = 8'h06; q_lat[11] = 0; q_gap[11] = 0; q_noise[11] = 0;
    for (int i = 12; i < NOPS; i++) begin
      q_op[i]    = 8'(((i * 7) & 8'h1F) | ((i % 9 == 0) ? 8'h80 : 8'h00));
      q_ad[i]    = 8'((i * 53 + 3) & 8'hFF);
      q_lat[i]   = i % 3;
      q_gap[i]   = (i % 4 == 0) ? 0 : (i % 3);
      q_noise[i] = (i % 5 == 2);
    end
  end

  initial begin
    int k, gapc, wcnt, cyc, idlec, cur_lat;
    bit cur_noise;
    rst_n = 1'b0; start = 1'b0; mem_ack = 1'b0; opcode = 8'h00; opaddr = 8'h00; mem_rdata = 8'h00;
    ph = 0; m_op = 0; m_addr = 0; m_rd = 0; m_wb = 0; m_tk = 0; m_cy = 0; m_ill = 0; m_b2b = 0;
    k = 0; gapc = 0; wcnt = 0; cyc = 0; idlec = 0; cur_lat = 0; cur_noise = 0;
    repeat (4) @(posedge clk);
    @(negedge clk);
    chk(!busy && !mem_req && !mem_we, "R1 busy/req/we in reset", {busy, mem_req, mem_we}, 8'h00);
    chk(!done && !taken && !carry, "R1 done/taken/carry in reset", {done, taken, carry}, 8'h00);
    rst_n = 1'b1;
    forever begin
      @(negedge clk);
      cyc++;
      if (cyc > 20000) begin
        chk(1'b0, "watchdog expired", 8'(k), 8'(NOPS));
        break;
      end
      // compare against model
      chk(busy === (ph != 0), "R9 busy", busy, (ph != 0));
      chk(mem_req === (ph == 1 || ph == 3), "R3 mem_req", mem_req, (ph == 1 || ph == 3));
      if (ph == 1 || ph == 3) chk(mem_addr === m_addr, "R3 mem_addr", mem_addr, m_addr);
      chk(mem_we === (ph == 3), "R4/R6 mem_we", mem_we, (ph == 3));
      if (ph == 3) chk(mem_wdata === m_wb, wo(m_addr) ? "R5 write-only wdata" : "R2/R4 wdata", mem_wdata, m_wb);
      chk(done === (ph == 4), m_ill ? "R11 done" : (m_b2b ? "R10 done" : "R8 done"), done, (ph == 4));
      chk(taken === (ph == 4 && m_tk), "R2/R6 taken", taken, (ph == 4 && m_tk));
      chk(carry === m_cy, "R7 carry", carry, m_cy);
      // drive start
      start = 1'b0;
      if (ph == 0 || ph == 4) begin
        if (k < NOPS && gapc >= q_gap[k]) begin
          start = 1'b1; opcode = q_op[k]; opaddr = q_ad[k];
          cur_lat = q_lat[k]; cur_noise = q_noise[k]; k++; gapc = 0;
        end else gapc++;
      end else if (cur_noise) begin
        start = 1'b1; opcode = 8'h13; opaddr = 8'hEE;
      end
      // drive memory acknowledge
      mem_ack = 1'b0;
      if (ph == 1 || ph == 3) begin
        if (wcnt >= cur_lat) begin
          mem_ack = 1'b1; wcnt = 0;
          if (ph == 1) mem_rdata = wo(m_addr) ? 8'hFF : mem[m_addr];
          else mem[m_addr] = mem_wdata;
        end else wcnt++;
      end
      // reference model next state
      case (ph)
        0, 4: begin
          if (start) begin
            m_b2b = (ph == 4);
            m_ill = (opcode[7:5] != 3'b000);
            m_op = opcode; m_addr = opaddr; m_tk = 1'b0;
            ph = m_ill ? 4 : 1;
          end else begin
            ph = 0; m_ill = 0; m_b2b = 0;
          end
        end
        1: if (mem_ack) begin m_rd = mem_rdata; ph = 2; end
        2: begin
          if (m_op[4]) begin
            m_wb = m_op[0] ? (m_rd & ~(8'h01 << m_op[3:1])) : (m_rd | (8'h01 << m_op[3:1]));
            ph = 3;
          end else begin
            m_cy = m_rd[m_op[3:1]];
            m_tk = m_op[0] ? !m_rd[m_op[3:1]] : m_rd[m_op[3:1]];
            ph = 4;
          end
        end
        3: if (mem_ack) ph = 4;
        default: ph = 0;
      endcase
      if (k == NOPS && ph == 0) idlec++;
      if (idlec > 3) break;
    end
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule